// File: doc/BRIEF.md
# Locality-Paged Interrupt Register Front End

This block is the 32-bit register slave that sits behind a memory window of a security-module host interface. The window spans five 4 KB pages, one per locality. The upper address bits pick the page and the low twelve bits pick the register within it. Each page carries its own interrupt-enable and interrupt-status registers. Every page also shows the same constant capability, vector and identity words. One level interrupt line is driven from the combined pending state of all pages.

Ownership of the interface is settled outside the block: an external arbiter presents the active locality on `active_loc`/`active_valid`. Pages that do not own the interface can still read most registers. Their writes to the gated registers are dropped, and their reads of the status word return all ones. Event pulses from the external command engine set status bits in the active page. Read data comes back one cycle after the request. A two-state reply machine handles this: `PH_IDLE` moves to `PH_REPLY` on a read request (transition *read_accept*). `PH_REPLY` returns to `PH_IDLE`, or stays in `PH_REPLY` if another read arrives (*reply_done* / *read_accept*).

Top module: `winreg_front`

## Requirements
- R1: The page equals req_addr[14:12] and the register offset equals req_addr[11:0]. Pages 0 to 4 exist. An access to pages 5 to 7 reads as all ones (cut to the access size), and a write there changes nothing.
- R2: rsp_valid is high in the cycle after a read request and only then, and rsp_rdata holds that read's data in the same cycle.
- R3: Offset 0x14 reads 0x20000697 on every page. This word is made of interrupt support bits 0,1,2,4,7, transfer-size code 3 in bits 10:9, and interface-version code 2 in bits 30:28.
- R4: On every page, offset 0x0C reads the vector number (default 10) and offset 0xF00 reads 0x14100100. That value is vendor 0x1014 in the low half and device 0x0001 in the high half, with the four bytes reversed. Offset 0xF04 reads the revision 0x01.
- R5: Any offset other than 0x00, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x24, 0x80, 0xF00 or 0xF04 reads as all ones, and writes to it or to a read-only offset are ignored.
- R6: req_size 0, 1 and 2 select 1, 2 and 4 bytes. Reads return the low bytes of the register with the upper bytes zero. A narrow write updates only the low bytes. Size 3, or an address that is not a multiple of the size, reads as 0xFFFFFFFF (size 3) or all ones cut to the size, and such a write is dropped.
- R7: Interrupt enable (offset 0x08) has these fields: bit 0 data-available, bit 1 status-valid, bit 2 locality-change, bits 4:3 trigger mode, bit 7 command-ready and bit 31 global. All other bits read zero.
- R8: Interrupt status (offset 0x10) bits are set in the active page by evt_i[0], evt_i[1] and evt_i[2] into bits 0, 1 and 2, and by evt_i[3] into bit 7. Writing 1 clears a bit (mask 0x87). Writing 0 never sets a bit. When a set and a clear hit the same bit in the same cycle, the bit ends set.
- R9: Writes to offsets 0x08, 0x10, 0x18, 0x24 and 0x80 are dropped unless active_valid is high and the page equals active_loc. Reads of 0x08 and 0x10 are not gated.
- R10: Offset 0x18 reads 0xFFFFFFFF from a page that is not active and zero from the active page. Offsets 0x00, 0x24 and 0x80 read zero.
- R11: irq_o is high exactly when some page has a bit set in both its enable and its status register. The line follows the register update with no further delay.
- R12: Reset clears every page's enable and status registers, irq_o and rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_valid | input | 1 | A locality owns the interface |
| active_loc | input | 3 | Index of the owning locality |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 half word, 2 word, 3 invalid |
| req_addr | input | 15 | Byte offset into the window |
| req_wdata | input | 32 | Write value, low bytes used for narrow writes |
| evt_i | input | 4 | One-cycle status events for the active page |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench sweeps every page, including the three missing ones, over every mapped offset plus neighbours, at every size. The sweep repeats under several ownership states, so a decoder that wraps page 5 onto page 0, or that matches offsets by masking instead of exact compare, shows wrong words at once. Ownership gating is probed by writing enable and status from foreign pages and reading them back through a page that may read them. A block that forgot the gate, or that gated reads as well, changes the readback. The set-beats-clear collision, narrow merges that must keep upper bytes, misaligned and size-3 drops, and an interrupt that must stay high after ownership moves away are each targeted. A bench model computes every expected word from the requirements.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    typedef enum logic [3:0] {
        RS_OWNER,
        RS_IEN,
        RS_IVEC,
        RS_IPEND,
        RS_CAPS,
        RS_STAT,
        RS_FIFO,
        RS_XFIFO,
        RS_IDENT,
        RS_REV,
        RS_NONE
    } reg_sel_e;

    typedef enum logic {
        PH_IDLE,
        PH_REPLY
    } reply_state_e;

    localparam int OFF_OWNER = 'h000;
    localparam int OFF_IEN   = 'h008;
    localparam int OFF_IVEC  = 'h00C;
    localparam int OFF_IPEND = 'h010;
    localparam int OFF_CAPS  = 'h014;
    localparam int OFF_STAT  = 'h018;
    localparam int OFF_FIFO  = 'h024;
    localparam int OFF_XFIFO = 'h080;
    localparam int OFF_IDENT = 'hF00;
    localparam int OFF_REV   = 'hF04;

    localparam logic [31:0] IEN_WMASK   = 32'h8000_009F;
    localparam logic [31:0] IPEND_WMASK = 32'h0000_0087;
    localparam logic [31:0] CAPS_WORD   = 32'h2000_0697;

endpackage

// File: rtl/winreg_decode.sv
module winreg_decode
    import winreg_pkg::*;
#(
    parameter int NUM_LOC   = 5,
    parameter int PAGE_BITS = 12,
    parameter int LOC_W     = 3
) (
    input  logic [PAGE_BITS+LOC_W-1:0] addr,
    input  logic [1:0]                 size,
    output logic [LOC_W-1:0]           loc,
    output logic                       page_ok,
    output logic                       shape_ok,
    output reg_sel_e                   sel,
    output logic [31:0]                lane_mask
);
    logic [PAGE_BITS-1:0] offset;

    assign loc     = addr[PAGE_BITS+LOC_W-1:PAGE_BITS];
    assign offset  = addr[PAGE_BITS-1:0];
    assign page_ok = (32'(loc) < NUM_LOC);

    always_comb begin
        unique case (offset)
            PAGE_BITS'(OFF_OWNER): sel = RS_OWNER;
            PAGE_BITS'(OFF_IEN):   sel = RS_IEN;
            PAGE_BITS'(OFF_IVEC):  sel = RS_IVEC;
            PAGE_BITS'(OFF_IPEND): sel = RS_IPEND;
            PAGE_BITS'(OFF_CAPS):  sel = RS_CAPS;
            PAGE_BITS'(OFF_STAT):  sel = RS_STAT;
            PAGE_BITS'(OFF_FIFO):  sel = RS_FIFO;
            PAGE_BITS'(OFF_XFIFO): sel = RS_XFIFO;
            PAGE_BITS'(OFF_IDENT): sel = RS_IDENT;
            PAGE_BITS'(OFF_REV):   sel = RS_REV;
            default:               sel = RS_NONE;
        endcase
    end

    always_comb begin
        unique case (size)
            2'd0: begin shape_ok = 1'b1;            lane_mask = 32'h0000_00FF; end
            2'd1: begin shape_ok = ~addr[0];        lane_mask = 32'h0000_FFFF; end
            2'd2: begin shape_ok = (addr[1:0] == 2'b00); lane_mask = 32'hFFFF_FFFF; end
            default: begin shape_ok = 1'b0;         lane_mask = 32'hFFFF_FFFF; end
        endcase
    end

endmodule

// File: rtl/winreg_irq_bank.sv
module winreg_irq_bank
    import winreg_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LOC_W-1:0]       wr_loc,
    input  logic                   wr_ien,
    input  logic                   wr_ipend,
    input  logic [31:0]            wdata,
    input  logic [31:0]            wmask,
    input  logic                   evt_valid,
    input  logic [LOC_W-1:0]       evt_loc,
    input  logic [3:0]             evt,
    output logic [NUM_LOC*32-1:0]  ien_all,
    output logic [NUM_LOC*32-1:0]  ipend_all,
    output logic                   irq
);
    logic [31:0]        evt_word;
    logic [NUM_LOC-1:0] pend;

    assign evt_word = {24'b0, evt[3], 4'b0, evt[2:0]};

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        logic [31:0] ien_q;
        logic [31:0] ipend_q;
        logic [31:0] set_v;
        logic [31:0] clr_v;
        logic        hit_w;
        logic        hit_e;

        always_comb begin
            hit_w = (wr_loc == LOC_W'(g));
            hit_e = evt_valid && (evt_loc == LOC_W'(g));
            set_v = hit_e ? evt_word : '0;
            clr_v = (wr_ipend && hit_w) ? (wdata & wmask & IPEND_WMASK) : '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ien_q   <= '0;
                ipend_q <= '0;
            end else begin
                if (wr_ien && hit_w)
                    ien_q <= ((ien_q & ~wmask) | (wdata & wmask)) & IEN_WMASK;
                ipend_q <= (ipend_q & ~clr_v) | set_v;
            end
        end

        assign ien_all[g*32 +: 32]   = ien_q;
        assign ipend_all[g*32 +: 32] = ipend_q;
        assign pend[g]               = |(ien_q & ipend_q);
    end

    assign irq = |pend;

endmodule

// File: rtl/winreg_rdmux.sv
module winreg_rdmux
    import winreg_pkg::*;
#(
    parameter int          IRQ_NUM = 10,
    parameter logic [15:0] VEN_ID  = 16'h1014,
    parameter logic [15:0] DEV_ID  = 16'h0001,
    parameter logic [7:0]  REV_ID  = 8'h01
) (
    input  reg_sel_e    sel,
    input  logic        page_ok,
    input  logic        shape_ok,
    input  logic        is_active,
    input  logic [31:0] ien_word,
    input  logic [31:0] ipend_word,
    input  logic [31:0] lane_mask,
    output logic [31:0] rdata
);
    localparam logic [31:0] ID_NATIVE = {DEV_ID, VEN_ID};
    localparam logic [31:0] ID_SWAPPED = {ID_NATIVE[7:0], ID_NATIVE[15:8],
                                          ID_NATIVE[23:16], ID_NATIVE[31:24]};

    logic [31:0] raw;

    always_comb begin
        unique case (sel)
            RS_OWNER: raw = '0;
            RS_IEN:   raw = ien_word;
            RS_IVEC:  raw = 32'(IRQ_NUM);
            RS_IPEND: raw = ipend_word;
            RS_CAPS:  raw = CAPS_WORD;
            RS_STAT:  raw = is_active ? '0 : '1;
            RS_FIFO:  raw = '0;
            RS_XFIFO: raw = '0;
            RS_IDENT: raw = ID_SWAPPED;
            RS_REV:   raw = 32'(REV_ID);
            default:  raw = '1;
        endcase
        if (!page_ok || !shape_ok)
            raw = '1;
        rdata = raw & lane_mask;
    end

endmodule

// File: rtl/winreg_front.sv
module winreg_front
    import winreg_pkg::*;
#(
    parameter int          NUM_LOC   = 5,
    parameter int          PAGE_BITS = 12,
    parameter int          LOC_W     = 3,
    parameter int          IRQ_NUM   = 10,
    parameter logic [15:0] VEN_ID    = 16'h1014,
    parameter logic [15:0] DEV_ID    = 16'h0001,
    parameter logic [7:0]  REV_ID    = 8'h01
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active_valid,
    input  logic [LOC_W-1:0]           active_loc,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [1:0]                 req_size,
    input  logic [PAGE_BITS+LOC_W-1:0] req_addr,
    input  logic [31:0]                req_wdata,
    input  logic [3:0]                 evt_i,
    output logic                       rsp_valid,
    output logic [31:0]                rsp_rdata,
    output logic                       irq_o
);
    logic [LOC_W-1:0]     loc;
    logic [LOC_W-1:0]     loc_idx;
    logic                 page_ok;
    logic                 shape_ok;
    reg_sel_e             sel;
    logic [31:0]          lane_mask;
    logic                 is_active;
    logic                 wr_go;
    logic                 rd_go;
    logic                 evt_valid;
    logic [NUM_LOC*32-1:0] ien_all;
    logic [NUM_LOC*32-1:0] ipend_all;
    logic [31:0]          rd_word;
    reply_state_e         state_q;
    reply_state_e         state_d;

    winreg_decode #(
        .NUM_LOC  (NUM_LOC),
        .PAGE_BITS(PAGE_BITS),
        .LOC_W    (LOC_W)
    ) u_dec (
        .addr     (req_addr),
        .size     (req_size),
        .loc      (loc),
        .page_ok  (page_ok),
        .shape_ok (shape_ok),
        .sel      (sel),
        .lane_mask(lane_mask)
    );

    assign is_active = active_valid && page_ok && (active_loc == loc);
    assign wr_go     = req_valid && req_write && page_ok && shape_ok && is_active;
    assign rd_go     = req_valid && !req_write;
    assign evt_valid = active_valid && (32'(active_loc) < NUM_LOC);
    assign loc_idx   = page_ok ? loc : '0;

    winreg_irq_bank #(
        .NUM_LOC(NUM_LOC),
        .LOC_W  (LOC_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_loc   (loc),
        .wr_ien   (wr_go && (sel == RS_IEN)),
        .wr_ipend (wr_go && (sel == RS_IPEND)),
        .wdata    (req_wdata),
        .wmask    (lane_mask),
        .evt_valid(evt_valid),
        .evt_loc  (active_loc),
        .evt      (evt_i),
        .ien_all  (ien_all),
        .ipend_all(ipend_all),
        .irq      (irq_o)
    );

    winreg_rdmux #(
        .IRQ_NUM(IRQ_NUM),
        .VEN_ID (VEN_ID),
        .DEV_ID (DEV_ID),
        .REV_ID (REV_ID)
    ) u_rd (
        .sel       (sel),
        .page_ok   (page_ok),
        .shape_ok  (shape_ok),
        .is_active (is_active),
        .ien_word  (ien_all[loc_idx*32 +: 32]),
        .ipend_word(ipend_all[loc_idx*32 +: 32]),
        .lane_mask (lane_mask),
        .rdata     (rd_word)
    );

    // reply state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PH_IDLE;
        else
            state_q <= state_d;
    end

    // next state: read_accept / reply_done
    always_comb begin
        unique case (state_q)
            PH_IDLE:  state_d = rd_go ? PH_REPLY : PH_IDLE;
            PH_REPLY: state_d = rd_go ? PH_REPLY : PH_IDLE;
            default:  state_d = PH_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rsp_rdata <= '0;
        else if (rd_go)
            rsp_rdata <= rd_word;
    end

    assign rsp_valid = (state_q == PH_REPLY);

endmodule

// File: rtl/winreg_checker.sv
module winreg_checker #(
    parameter int NUM_LOC   = 5,
    parameter int PAGE_BITS = 12,
    parameter int LOC_W     = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       active_valid,
    input logic [LOC_W-1:0]           active_loc,
    input logic                       req_valid,
    input logic                       req_write,
    input logic [1:0]                 req_size,
    input logic [PAGE_BITS+LOC_W-1:0] req_addr,
    input logic                       rsp_valid,
    input logic [31:0]                rsp_rdata,
    input logic                       irq_o,
    input logic [NUM_LOC*32-1:0]      ien_all
);
    logic [LOC_W-1:0]     pg;
    logic [PAGE_BITS-1:0] off;
    logic                 owner;
    logic                 word_rd;

    assign pg      = req_addr[PAGE_BITS+LOC_W-1:PAGE_BITS];
    assign off     = req_addr[PAGE_BITS-1:0];
    assign owner   = active_valid && (active_loc == pg);
    assign word_rd = req_valid && !req_write && (req_size == 2'd2) && (32'(pg) < NUM_LOC);

    a_r2_reply_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    a_r2_no_stray_reply: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    a_r10_foreign_status_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (word_rd && (off == PAGE_BITS'('h018)) && !owner) |=> (rsp_rdata == 32'hFFFF_FFFF));

    a_r3_caps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (word_rd && (off == PAGE_BITS'('h014))) |=> (rsp_rdata == 32'h2000_0697));

    a_r9_foreign_write_holds_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !owner) |=> (ien_all == $past(ien_all)));

    a_r11_quiet_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_all == '0) |-> !irq_o);

endmodule

bind winreg_front winreg_checker #(
    .NUM_LOC  (NUM_LOC),
    .PAGE_BITS(PAGE_BITS),
    .LOC_W    (LOC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_valid(active_valid),
    .active_loc  (active_loc),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .irq_o       (irq_o),
    .ien_all     (ien_all)
);

// File: tb/tb_winreg_front.sv
module tb_winreg_front;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        active_valid;
    logic [2:0]  active_loc;
    logic        req_valid;
    logic        req_write;
    logic [1:0]  req_size;
    logic [14:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  evt_i;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq_o;

    always #2 clk = ~clk;

    winreg_front dut (
        .clk(clk), .rst_n(rst_n), .active_valid(active_valid), .active_loc(active_loc),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .evt_i(evt_i),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_en [5];
    logic [31:0] m_sts[5];
    bit          act_v;
    int          act_l;

    int offs[15] = '{'h000, 'h004, 'h008, 'h009, 'h00A, 'h00C, 'h010, 'h014,
                     'h018, 'h01C, 'h024, 'h080, 'hF00, 'hF04, 'hF08};

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] lane(int sz);
        return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic bit shape(int a, int sz);
        return (sz == 0) || (sz == 1 && a % 2 == 0) || (sz == 2 && a % 4 == 0);
    endfunction

    function automatic bit owns(int pg);
        return act_v && (pg == act_l) && (pg < 5);
    endfunction

    function automatic logic [31:0] mexp(int a, int sz);
        int pg = a >> 12;
        int off = a & 'hFFF;
        logic [31:0] v;
        if (!shape(a, sz) || pg > 4) return lane(sz);
        case (off)
            'h000, 'h024, 'h080: v = 32'h0;
            'h008: v = m_en[pg];
            'h00C: v = 32'd10;
            'h010: v = m_sts[pg];
            'h014: v = 32'h2000_0697;
            'h018: v = owns(pg) ? 32'h0 : 32'hFFFF_FFFF;
            'hF00: v = 32'h1410_0100;
            'hF04: v = 32'h1;
            default: v = 32'hFFFF_FFFF;
        endcase
        return v & lane(sz);
    endfunction

    function automatic string tag_of(int a, int sz);
        int pg = a >> 12;
        int off = a & 'hFFF;
        if (pg > 4) return "R1";
        if (!shape(a, sz)) return "R6";
        case (off)
            'h014: return "R3";
            'h00C, 'hF00, 'hF04: return "R4";
            'h008: return "R7";
            'h010: return "R8";
            'h000, 'h018, 'h024, 'h080: return "R10";
            default: return "R5";
        endcase
    endfunction

    function automatic logic m_irq();
        logic r = 1'b0;
        for (int i = 0; i < 5; i++) r |= |(m_en[i] & m_sts[i]);
        return r;
    endfunction

    task automatic mwrite(int a, int sz, logic [31:0] d);
        int pg = a >> 12;
        int off = a & 'hFFF;
        logic [31:0] m = lane(sz);
        if (!shape(a, sz) || pg > 4 || !owns(pg)) return;
        if (off == 'h008) m_en[pg] = ((m_en[pg] & ~m) | (d & m)) & 32'h8000_009F;
        if (off == 'h010) m_sts[pg] = m_sts[pg] & ~(d & m & 32'h87);
    endtask

    task automatic mevent(logic [3:0] ev);
        if (act_v && act_l < 5)
            m_sts[act_l] |= {24'b0, ev[3], 4'b0, ev[2:0]};
    endtask

    task automatic access(bit w, int a, int sz, logic [31:0] d, logic [3:0] ev);
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = 15'(a);
        req_size = 2'(sz); req_wdata = d; evt_i = ev;
        exp = mexp(a, sz);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; evt_i = 4'h0;
        if (!w) begin
            check("R2", {31'b0, rsp_valid}, 32'h1, "reply valid");
            check(tag_of(a, sz), rsp_rdata, exp, $sformatf("read %h size %0d", a, sz));
        end else begin
            check("R2", {31'b0, rsp_valid}, 32'h0, "no reply on write");
            mwrite(a, sz, d);
        end
        mevent(ev);
        check("R11", {31'b0, irq_o}, {31'b0, m_irq()}, $sformatf("irq after %h", a));
    endtask

    task automatic set_owner(bit v, int l);
        @(negedge clk);
        active_valid = v; active_loc = 3'(l);
        act_v = v; act_l = l;
    endtask

    task automatic sweep();
        for (int pg = 0; pg < 8; pg++)
            for (int k = 0; k < 15; k++)
                for (int sz = 0; sz < 4; sz++)
                    access(0, pg * 'h1000 + offs[k], sz, 32'h0, 4'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 5; i++) begin m_en[i] = '0; m_sts[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", {31'b0, irq_o}, 32'h0, "irq after reset");
        check("R12", {31'b0, rsp_valid}, 32'h0, "reply after reset");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        active_valid = 0; active_loc = 0; req_valid = 0; req_write = 0;
        req_size = 0; req_addr = 0; req_wdata = 0; evt_i = 0;
        act_v = 0; act_l = 0;
        do_reset();

        // R10 R12: nobody owns the interface, every page's status reads ones
        sweep();

        // R9 R7: only page 1 may write its enable
        set_owner(1, 1);
        for (int pg = 0; pg < 8; pg++)
            access(1, pg * 'h1000 + 'h008, 2, 32'hFFFF_FFFF, 4'h0);
        sweep();

        // R8 R11: event raises irq, write-1 clears it
        access(1, 'h1010, 2, 32'h0, 4'b0001);
        access(1, 'h1010, 2, 32'h1, 4'h0);
        // R8: writing ones where no bit is set creates nothing
        access(1, 'h1010, 2, 32'hFFFF_FFFF, 4'h0);
        // R8: set and clear collide, set wins
        access(1, 'h1010, 2, 32'h81, 4'b1001);
        access(0, 'h1010, 2, 32'h0, 4'h0);
        // R9: foreign page cannot clear page 1
        access(1, 'h0010, 2, 32'h87, 4'h0);
        set_owner(1, 3);
        access(1, 'h1010, 2, 32'h87, 4'h0);
        // R11: page 1 still pending while page 3 owns
        access(0, 'h1010, 2, 32'h0, 4'b0110);
        // R6: narrow and malformed writes on page 3
        access(1, 'h3008, 0, 32'hFFFF_FFFF, 4'h0);
        access(1, 'h3008, 3, 32'hFFFF_FFFF, 4'h0);
        access(1, 'h3009, 1, 32'hFFFF_FFFF, 4'h0);
        access(1, 'h3008, 2, 32'h8000_0004, 4'h0);
        access(1, 'h3008, 0, 32'h0000_0001, 4'h0);
        // R5: writes to read-only and unmapped offsets
        access(1, 'h300C, 2, 32'h0, 4'h0);
        access(1, 'h3F00, 2, 32'h0, 4'h0);
        access(1, 'h3004, 2, 32'h0, 4'h0);
        // R1: owner index beyond the last page drops events
        set_owner(1, 6);
        access(0, 'h6010, 2, 32'h0, 4'b1111);
        access(1, 'h6008, 2, 32'hFFFF_FFFF, 4'h0);
        sweep();

        // R12: reset clears every page
        do_reset();
        set_owner(0, 0);
        sweep();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule